// File: doc/BRIEF.md
# Interrupt Priority Level Evaluator

This block decides which interrupt priority level the processor should take next. It watches the current processor priority level, a memory-error flag, a 16-bit software request word and four banks of 32 hardware request bits. The hardware banks serve levels 0x14 to 0x17. Every cycle it reports the winning level, or zero when nothing is eligible.

Three classes are resolved in a fixed order:

- The memory-error level comes first.
- The hardware levels come next. They are scanned from the top down, and the scan stops once it reaches the current level.
- The software levels come last. Only requests above the current level count.

Hardware request bits are held in pending registers inside the block. When the processor acknowledges a hardware level, the block clears the lowest-numbered pending bit of that level. It then returns the vector for that bit from a parameter table. The processor uses that vector to dispatch.

Top module: `irq_level_eval`

## Requirements
- R1: After reset, the outputs are all zero: the reported level, the acknowledge hit flag, the acknowledge vector and every pending hardware bit.
- R2: A one on `hwSet` sets the matching pending bit at the next clock edge. Bits 32k+31..32k of `hwSet` and `hwPending` belong to level 0x14+k. A pending bit stays set until an acknowledge clears it.
- R3: When the memory-error flag is set and the current level is below the memory-error level (default 0x1D), the reported level is the memory-error level, whatever else is pending.
- R4: Otherwise the hardware levels are scanned from 0x17 down to 0x14. The first level above the current level with any pending bit is reported.
- R5: If the scan reaches a hardware level at or below the current level before finding a pending one, the reported level is zero. Software requests are then not considered.
- R6: Software requests are considered only when no hardware level wins and the current level is below 15. Only bits numbered above the current level count, and the highest such bit number is reported. Bit 0 never counts.
- R7: When no class yields a level, the reported level is zero.
- R8: An acknowledge at a hardware level with pending bits clears that level's lowest-numbered pending bit. The next cycle it shows the hit flag and that bit's table vector. The default table gives 0x200 + 0x80*(level-0x14) + 4*bit. At most one pending bit is cleared per acknowledge.
- R9: An acknowledge at a level outside 0x14 to 0x17, or at a level with no pending bits, returns vector zero with the hit flag low. The pending bits are left unchanged.
- R10: When a request sets a bit in the same cycle that an acknowledge clears it, the bit stays pending.
- R11: The reported level uses the pending bits as they stood before the clock edge, so a new hardware request first affects the level two edges after it is driven. Changes on the current level, the memory-error flag and the software word show after one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| curLevel | input | 5 | Current processor priority level |
| memErr | input | 1 | Memory-error interrupt flag |
| swReq | input | 16 | Software request bits, bit n requests level n |
| hwSet | input | 128 | Hardware request set pulses, 32 bits per level from 0x14 up |
| ackValid | input | 1 | Acknowledge strobe |
| ackLevel | input | 5 | Level being acknowledged |
| winLevel | output | 5 | Winning level, zero when none |
| ackHit | output | 1 | Previous acknowledge consumed a pending bit |
| ackVector | output | 16 | Vector of the consumed bit, zero on a miss |
| hwPending | output | 128 | Pending hardware request bits |

## Verification
The winning level, acknowledge flag and acknowledge vector are each due one clock edge after the inputs that produce them. A hardware request changes the pending bits at that same edge, so it reaches the level one edge later. The bench drives its inputs just after a falling edge. At that point it computes, from its own model of the pending bits as they stood before the coming rising edge, what every output must be after that edge. At the next falling edge it compares the outputs, so each comparison lands exactly one edge after its stimulus. A directed case tags the one-edge lag of a fresh hardware request explicitly.

// File: rtl/irq_eval_pkg.sv
package irq_eval_pkg;

  localparam int LVL_W     = 5;
  localparam int HW_LEVELS = 4;
  localparam int REQ_BITS  = 32;
  localparam int HW_IDX_W  = $clog2(HW_LEVELS);
  localparam int BIT_IDX_W = $clog2(REQ_BITS);
  localparam int DEF_VEC_W = 16;
  localparam int TABLE_W   = HW_LEVELS * REQ_BITS * DEF_VEC_W;

  // strobes from the resolver to the register datapath
  typedef struct packed {
    logic                 ackFire;
    logic [HW_IDX_W-1:0]  ackLvl;
    logic [BIT_IDX_W-1:0] ackBit;
    logic [LVL_W-1:0]     nextLevel;
  } ctl_strobe_t;

  // default vector: 0x200 + 0x80 per hardware level + 4 per request bit
  function automatic logic [TABLE_W-1:0] defaultVecTable();
    logic [TABLE_W-1:0] t;
    t = '0;
    for (int k = 0; k < HW_LEVELS; k++) begin
      for (int b = 0; b < REQ_BITS; b++) begin
        t[(k*REQ_BITS+b)*DEF_VEC_W +: DEF_VEC_W] =
          DEF_VEC_W'(32'h200 + 32'h80 * k + 4 * b);
      end
    end
    return t;
  endfunction

endpackage

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
  parameter int W = 32,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign any = |vec;

endmodule

// File: rtl/irq_eval_ctl.sv
module irq_eval_ctl
  import irq_eval_pkg::*;
#(
  parameter int MEM_LEVEL = 'h1D,
  parameter int HW_MIN    = 'h14,
  parameter int SW_MAX    = 15
) (
  input  logic [LVL_W-1:0]              curLevel,
  input  logic                          memErr,
  input  logic [SW_MAX:0]               swReq,
  input  logic [HW_LEVELS*REQ_BITS-1:0] pend,
  input  logic                          ackValid,
  input  logic [LVL_W-1:0]              ackLevel,
  output ctl_strobe_t                   strobes
);

  logic [HW_LEVELS-1:0] lvlAny;
  logic [BIT_IDX_W-1:0] lvlLow [HW_LEVELS];

  for (genvar k = 0; k < HW_LEVELS; k++) begin : g_pick
    irq_lsb_pick #(.W(REQ_BITS)) u_pick (
      .vec(pend[k*REQ_BITS +: REQ_BITS]),
      .any(lvlAny[k]),
      .idx(lvlLow[k])
    );
  end

  logic [HW_IDX_W-1:0] ackIdx;
  logic                ackInRange;
  logic [LVL_W-1:0]    lvl;
  logic                found;

  always_comb begin
    // acknowledge decode
    ackIdx     = '0;
    ackInRange = 1'b0;
    for (int k = 0; k < HW_LEVELS; k++) begin
      if (int'(ackLevel) == HW_MIN + k) begin
        ackInRange = 1'b1;
        ackIdx     = HW_IDX_W'(k);
      end
    end

    // level resolution: memory error, hardware top-down, software
    lvl   = '0;
    found = 1'b0;
    if (memErr && (int'(curLevel) < MEM_LEVEL)) begin
      lvl   = LVL_W'(MEM_LEVEL);
      found = 1'b1;
    end
    for (int k = HW_LEVELS - 1; k >= 0; k--) begin
      if (!found) begin
        if (HW_MIN + k <= int'(curLevel)) begin
          found = 1'b1;
          lvl   = '0;
        end else if (lvlAny[k]) begin
          found = 1'b1;
          lvl   = LVL_W'(HW_MIN + k);
        end
      end
    end
    if (!found && (int'(curLevel) < SW_MAX)) begin
      for (int b = 1; b <= SW_MAX; b++) begin
        if (swReq[b] && (b > int'(curLevel))) lvl = LVL_W'(b);
      end
    end

    strobes.ackFire   = ackValid && ackInRange && lvlAny[ackIdx];
    strobes.ackLvl    = ackIdx;
    strobes.ackBit    = lvlLow[ackIdx];
    strobes.nextLevel = lvl;
  end

endmodule

// File: rtl/irq_eval_dp.sv
module irq_eval_dp
  import irq_eval_pkg::*;
#(
  parameter int VEC_W = DEF_VEC_W,
  parameter logic [HW_LEVELS*REQ_BITS*VEC_W-1:0] VEC_TABLE = defaultVecTable()
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [HW_LEVELS*REQ_BITS-1:0] hwSet,
  input  ctl_strobe_t                   strobes,
  output logic [HW_LEVELS*REQ_BITS-1:0] pendFlat,
  output logic [LVL_W-1:0]              winLevel,
  output logic                          ackHit,
  output logic [VEC_W-1:0]              ackVector
);

  for (genvar k = 0; k < HW_LEVELS; k++) begin : g_lvl
    logic [REQ_BITS-1:0] clrMask;
    logic [REQ_BITS-1:0] pendQ;

    always_comb begin
      clrMask = '0;
      if (strobes.ackFire && (strobes.ackLvl == HW_IDX_W'(k)))
        clrMask[strobes.ackBit] = 1'b1;
    end

    // a set in the same cycle as a clear keeps the bit pending
    always_ff @(posedge clk) begin
      if (!rst_n) pendQ <= '0;
      else        pendQ <= (pendQ & ~clrMask) | hwSet[k*REQ_BITS +: REQ_BITS];
    end

    assign pendFlat[k*REQ_BITS +: REQ_BITS] = pendQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      winLevel  <= '0;
      ackHit    <= 1'b0;
      ackVector <= '0;
    end else begin
      winLevel  <= strobes.nextLevel;
      ackHit    <= strobes.ackFire;
      ackVector <= strobes.ackFire
                 ? VEC_TABLE[(int'(strobes.ackLvl) * REQ_BITS + int'(strobes.ackBit)) * VEC_W +: VEC_W]
                 : '0;
    end
  end

  assert_setWins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pendFlat & $past(hwSet)) == $past(hwSet)));

  assert_noSpontaneousClear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.ackFire |=> ((pendFlat & $past(pendFlat)) == $past(pendFlat)));

  assert_singleClear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.ackFire |=> ($countones($past(pendFlat) & ~pendFlat) <= 1));

endmodule

// File: rtl/irq_level_eval.sv
module irq_level_eval
  import irq_eval_pkg::*;
#(
  parameter int MEM_LEVEL = 'h1D,
  parameter int HW_MIN    = 'h14,
  parameter int SW_MAX    = 15,
  parameter int VEC_W     = DEF_VEC_W,
  parameter logic [HW_LEVELS*REQ_BITS*VEC_W-1:0] VEC_TABLE = defaultVecTable(),
  localparam int SW_W     = SW_MAX + 1,
  localparam int PEND_W   = HW_LEVELS * REQ_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  curLevel,
  input  logic              memErr,
  input  logic [SW_W-1:0]   swReq,
  input  logic [PEND_W-1:0] hwSet,
  input  logic              ackValid,
  input  logic [LVL_W-1:0]  ackLevel,
  output logic [LVL_W-1:0]  winLevel,
  output logic              ackHit,
  output logic [VEC_W-1:0]  ackVector,
  output logic [PEND_W-1:0] hwPending
);

  ctl_strobe_t strobes;

  irq_eval_ctl #(
    .MEM_LEVEL(MEM_LEVEL),
    .HW_MIN   (HW_MIN),
    .SW_MAX   (SW_MAX)
  ) u_ctl (
    .curLevel(curLevel),
    .memErr  (memErr),
    .swReq   (swReq),
    .pend    (hwPending),
    .ackValid(ackValid),
    .ackLevel(ackLevel),
    .strobes (strobes)
  );

  irq_eval_dp #(
    .VEC_W    (VEC_W),
    .VEC_TABLE(VEC_TABLE)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .hwSet    (hwSet),
    .strobes  (strobes),
    .pendFlat (hwPending),
    .winLevel (winLevel),
    .ackHit   (ackHit),
    .ackVector(ackVector)
  );

  // observation at the ports: is the acknowledged level empty or out of range
  logic ackLvlEmpty;
  always_comb begin
    ackLvlEmpty = 1'b1;
    for (int k = 0; k < HW_LEVELS; k++) begin
      if ((int'(ackLevel) == HW_MIN + k) && (|hwPending[k*REQ_BITS +: REQ_BITS]))
        ackLvlEmpty = 1'b0;
    end
  end

  assert_memErrFirst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (memErr && (int'(curLevel) < MEM_LEVEL)) |=> (int'(winLevel) == MEM_LEVEL));

  assert_aboveCurrent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((winLevel == '0) || (winLevel > $past(curLevel))));

  assert_emptyAckZero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ackValid && ackLvlEmpty) |=> (!ackHit && (ackVector == '0)));

endmodule

// File: tb/irq_level_eval_tb.sv
module irq_level_eval_tb;

  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [4:0]   curLevel;
  logic         memErr;
  logic [15:0]  swReq;
  logic [127:0] hwSet;
  logic         ackValid;
  logic [4:0]   ackLevel;
  logic [4:0]   winLevel;
  logic         ackHit;
  logic [15:0]  ackVector;
  logic [127:0] hwPending;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_level_eval u_dut (
    .clk(clk), .rst_n(rst_n), .curLevel(curLevel), .memErr(memErr),
    .swReq(swReq), .hwSet(hwSet), .ackValid(ackValid), .ackLevel(ackLevel),
    .winLevel(winLevel), .ackHit(ackHit), .ackVector(ackVector),
    .hwPending(hwPending)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0]  mPend [4];
  logic [4:0]   expLevel;
  logic         expHit;
  logic [15:0]  expVec;
  logic [127:0] expPend;
  string        lvlTagQ, ackTagQ, pendTagQ;

  task automatic check(input string tag, input string what, input logic ok,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference resolution from the requirements
  function automatic logic [4:0] refEval(input logic [4:0] cur, input logic m,
                                         input logic [15:0] sw, output string tag);
    if (m && cur < 5'h1D) begin tag = "R3"; return 5'h1D; end
    for (int k = 3; k >= 0; k--) begin
      if (20 + k <= int'(cur)) begin tag = "R5"; return 5'd0; end
      if (mPend[k] != 32'd0) begin tag = "R4"; return 5'(20 + k); end
    end
    if (cur >= 5'd15) begin tag = "R7"; return 5'd0; end
    for (int b = 15; b > int'(cur); b--) begin
      if (sw[b]) begin tag = "R6"; return 5'(b); end
    end
    tag = "R7";
    return 5'd0;
  endfunction

  task automatic checkAll();
    check(lvlTagQ, "winLevel", winLevel == expLevel, 128'(winLevel), 128'(expLevel));
    check(ackTagQ, "ackHit", ackHit == expHit, 128'(ackHit), 128'(expHit));
    check(ackTagQ, "ackVector", ackVector == expVec, 128'(ackVector), 128'(expVec));
    check(pendTagQ, "hwPending", hwPending == expPend, hwPending, expPend);
  endtask

  task automatic step(input logic [4:0] cur, input logic m, input logic [15:0] sw,
                      input logic [127:0] set, input logic av, input logic [4:0] al,
                      input string lvlOverride);
    string t;
    int k;
    @(negedge clk);
    checkAll();
    curLevel = cur; memErr = m; swReq = sw; hwSet = set; ackValid = av; ackLevel = al;
    expLevel = refEval(cur, m, sw, t);
    lvlTagQ  = (lvlOverride != "") ? lvlOverride : t;
    expHit = 1'b0; expVec = 16'd0; ackTagQ = "R9"; pendTagQ = "R2";
    k = int'(al) - 20;
    if (av && k >= 0 && k < 4 && mPend[k] != 32'd0) begin
      for (int b = 31; b >= 0; b--) begin
        if (mPend[k][b]) expVec = 16'(32'h200 + 32'h80 * k + 4 * b);
      end
      for (int b = 0; b < 32; b++) begin
        if (mPend[k][b]) begin
          mPend[k][b] = 1'b0;
          if (set[k*32 + b]) begin ackTagQ = "R10"; pendTagQ = "R10"; end
          else ackTagQ = "R8";
          break;
        end
      end
      expHit = 1'b1;
    end
    for (int j = 0; j < 4; j++) begin
      mPend[j] = mPend[j] | set[j*32 +: 32];
      expPend[j*32 +: 32] = mPend[j];
    end
  endtask

  function automatic logic [127:0] oneBit(input int lvl, input int b);
    logic [127:0] v = '0;
    v[(lvl - 20) * 32 + b] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; curLevel = '0; memErr = 0; swReq = '0; hwSet = '0;
    ackValid = 0; ackLevel = '0;
    for (int j = 0; j < 4; j++) mPend[j] = '0;
    expLevel = '0; expHit = 0; expVec = '0; expPend = '0;
    lvlTagQ = "R1"; ackTagQ = "R1"; pendTagQ = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: a fresh hardware request is not yet seen by the level
    step(5'd0, 0, 16'h0, oneBit('h14, 2), 0, 5'd0, "R11");
    step(5'd0, 0, 16'h0, '0, 0, 5'd0, "R11");
    // R3: memory error beats pending hardware
    step(5'd5, 1, 16'hFFFF, oneBit('h17, 0), 0, 5'd0, "");
    step(5'd5, 1, 16'hFFFF, '0, 0, 5'd0, "R3");
    // R5: current level above level 0x17 blocks hardware, memory error ignored at 0x1D
    step(5'h1D, 1, 16'hFFFF, '0, 0, 5'd0, "R5");
    step(5'h16, 0, 16'hFFFF, '0, 0, 5'd0, "R4");
    // clear hardware to reach software checks
    step(5'd0, 0, 16'h0, '0, 1, 5'h17, "");
    step(5'd0, 0, 16'h0, '0, 1, 5'h14, "");
    // R6 / R7: software thresholds
    step(5'd14, 0, 16'h8000, '0, 0, 5'd0, "R6");
    step(5'd15, 0, 16'hFFFF, '0, 0, 5'd0, "R7");
    step(5'd0, 0, 16'h0001, '0, 0, 5'd0, "R6");
    step(5'd3, 0, 16'h0418, '0, 0, 5'd0, "R6");
    // R8: lowest bit first, then the next, then empty (R9)
    step(5'd31, 0, 16'h0, oneBit('h15, 5) | oneBit('h15, 9), 0, 5'd0, "");
    step(5'd31, 0, 16'h0, '0, 1, 5'h15, "");
    step(5'd31, 0, 16'h0, '0, 1, 5'h15, "");
    step(5'd31, 0, 16'h0, '0, 1, 5'h15, "");
    // R9: out-of-range acknowledge
    step(5'd31, 0, 16'h0, oneBit('h16, 7), 0, 5'd0, "");
    step(5'd31, 0, 16'h0, '0, 1, 5'h13, "");
    step(5'd31, 0, 16'h0, '0, 1, 5'h18, "");
    // R10: same-cycle set and clear on the lowest bit
    step(5'd31, 0, 16'h0, oneBit('h16, 7), 1, 5'h16, "");
    step(5'd31, 0, 16'h0, '0, 1, 5'h16, "");

    // constrained random mix
    for (int it = 0; it < 3000; it++) begin
      logic [127:0] set = '0;
      logic [4:0] cur;
      logic [4:0] al;
      for (int j = 0; j < 4; j++) begin
        if ($urandom_range(0, 3) == 0) set[j*32 + $urandom_range(0, 31)] = 1'b1;
      end
      cur = ($urandom_range(0, 1) == 0) ? 5'($urandom_range(0, 15)) : 5'($urandom_range(0, 31));
      al  = 5'($urandom_range(18, 24));
      step(cur, ($urandom_range(0, 7) == 0), 16'($urandom & $urandom),
           set, ($urandom_range(0, 1) == 1), al, "");
    end
    @(negedge clk);
    checkAll();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule